// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block moves the bits of a data operand left or right by a run-time amount, in a single pass through a logarithmic stage network. A 3-bit operation code picks one of six shift flavours: zero-filling left and right, arithmetic left and right, a two-way shift whose direction comes from the sign of the amount, and a two-way shift whose vacated positions are left undefined, as an indexed part-select leaves them. Two flags say whether the operand and the amount are to be read as signed.

The operand is first widened to an internal width equal to the larger of the operand and result widths, then shifted, and the low bits form the result. The result can be taken straight from the logic or, when the `REG_OUT` parameter is set, from one output register placed after the logic to ease timing.

Top module: `shf_unit`

## Requirements
- R1: Operation code 0 (zero-fill left) shifts the widened operand toward the MSB by the unsigned amount, placing 0 in every vacated low bit.
- R2: Operation code 1 (zero-fill right) shifts the widened operand toward the LSB by the unsigned amount, placing 0 in every vacated high bit.
- R3: Operation code 2 (arithmetic left) gives a result identical to operation code 0 for every operand, amount and flag setting.
- R4: Operation code 3 (arithmetic right) fills vacated high bits with the MSB of the widened operand when the operand-signed flag is 1, and with 0 when it is 0.
- R5: In operation codes 0 to 3 the amount is always read as unsigned; the amount-signed flag has no effect on the result.
- R6: An amount greater than or equal to the internal width gives a result made only of fill bits (0 for codes 0, 1, 2 and for code 4 shifting right; the sign fill of R4 for code 3).
- R7: Operation code 4 (two-way) shifts right with zero fill when the amount is unsigned or non-negative; when the amount-signed flag is 1 and the amount's MSB is 1, it shifts left with zero fill by the amount's magnitude.
- R8: Operation code 5 (two-way, undefined fill) places every surviving bit exactly where code 4 would, and drives every vacated position to X.
- R9: When the operand-signed flag is 1 the operand is sign-extended to the internal width max(A_WIDTH, Y_WIDTH) before shifting, otherwise zero-extended; the result is the low Y_WIDTH bits.
- R10: Operation codes 6 and 7 drive the result to all zeros.
- R11: With REG_OUT set, the result appears one clock after its inputs and the asynchronous active-low reset clears it to zero; with REG_OUT clear the result follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op | input | 3 | Operation code (0..5 valid, 6 and 7 give zero) |
| a_signed | input | 1 | Operand is signed: sign-extend before shifting |
| b_signed | input | 1 | Amount is signed (used by codes 4 and 5 only) |
| a | input | A_WIDTH | Data operand |
| b | input | B_WIDTH | Shift amount |
| y | output | Y_WIDTH | Shifted result |

## Verification
The hardest situations to reach are the two-way modes with a negative amount at the extremes, the most negative code whose magnitude needs one more bit than the amount port, and amounts that reach or pass the internal width where every stage is bypassed by the fill path. Random stimulus rarely lands on these, so the bench drives them directly for every operation code, including the most negative amount and an amount-signed flag raised in the plain modes, then mixes them with thousands of random operations over all eight codes. In the undefined-fill mode the bench computes which bit positions survive and compares only those, since the vacated ones carry no defined value.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [2:0] {
      OP_LSL     = 3'd0,
      OP_LSR     = 3'd1,
      OP_ASL     = 3'd2,
      OP_ASR     = 3'd3,
      OP_BIDIR   = 3'd4,
      OP_BIDIR_X = 3'd5
   } shf_op_e;

   function automatic int max_i(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   function automatic int stage_cnt(input int w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/shf_extend.sv
module shf_extend #(
   parameter int AW = 8,
   parameter int W  = 8
) (
   input  logic          a_signed,
   input  logic [AW-1:0] a,
   output logic [W-1:0]  ext
);

   generate
      if (AW > W) begin : g_bad
         $error("shf_extend: operand wider than internal width");
      end else if (AW == W) begin : g_same
         assign ext = a;
      end else begin : g_widen
         logic top_bit;
         assign top_bit = a_signed & a[AW-1];
         assign ext     = {{(W-AW){top_bit}}, a};
      end
   endgenerate

endmodule

// File: rtl/shf_amount.sv
module shf_amount #(
   parameter int BW = 4
) (
   input  logic        use_sign,
   input  logic [BW-1:0] b,
   output logic        neg,
   output logic [BW:0] mag
);

   logic [BW:0] b_sx;

   assign neg  = use_sign & b[BW-1];
   assign b_sx = {neg, b};
   assign mag  = neg ? (~b_sx + 1'b1) : b_sx;

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int W  = 8,
   parameter int MW = 4
) (
   input  logic [W-1:0]  din,
   input  logic          fill,
   input  logic          left,
   input  logic [MW-1:0] mag,
   output logic [W-1:0]  dout,
   output logic [W-1:0]  keep
);

   import shf_pkg::*;

   localparam int S = stage_cnt(W);

   logic [W-1:0] rin;
   logic [W-1:0] dst [0:S];
   logic [W-1:0] mst [0:S];
   logic [W-1:0] rout;
   logic [W-1:0] rkeep;
   logic         ovf;

   // Left shifts run through the same right-shift network on a mirrored word.
   generate
      for (genvar i = 0; i < W; i++) begin : g_mir_in
         assign rin[i] = left ? din[W-1-i] : din[i];
      end
   endgenerate

   assign dst[0] = rin;
   assign mst[0] = '1;

   generate
      for (genvar k = 0; k < S; k++) begin : g_stage
         localparam int D = 1 << k;
         if (k < MW && D < W) begin : g_live
            assign dst[k+1] = mag[k] ? {{D{fill}}, dst[k][W-1:D]} : dst[k];
            assign mst[k+1] = mag[k] ? {{D{1'b0}}, mst[k][W-1:D]} : mst[k];
         end else begin : g_pass
            assign dst[k+1] = dst[k];
            assign mst[k+1] = mst[k];
         end
      end
   endgenerate

   assign ovf   = ({{(32-MW){1'b0}}, mag} >= 32'(W));
   assign rout  = ovf ? {W{fill}} : dst[S];
   assign rkeep = ovf ? '0 : mst[S];

   generate
      for (genvar i = 0; i < W; i++) begin : g_mir_out
         assign dout[i] = left ? rout[W-1-i]  : rout[i];
         assign keep[i] = left ? rkeep[W-1-i] : rkeep[i];
      end
   endgenerate

endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
   parameter int A_WIDTH = 12,
   parameter int B_WIDTH = 5,
   parameter int Y_WIDTH = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         op,
   input  logic               a_signed,
   input  logic               b_signed,
   input  logic [A_WIDTH-1:0] a,
   input  logic [B_WIDTH-1:0] b,
   output logic [Y_WIDTH-1:0] y
);

   import shf_pkg::*;

   localparam int WW = max_i(A_WIDTH, Y_WIDTH);
   localparam int MW = B_WIDTH + 1;

   generate
      if (A_WIDTH < 1 || Y_WIDTH < 1) begin : g_chk_w
         $error("shf_unit: widths must be at least 1");
      end
      if (B_WIDTH < 1 || B_WIDTH > 30) begin : g_chk_b
         $error("shf_unit: B_WIDTH must lie in 1..30");
      end
      if (WW < 2) begin : g_chk_ww
         $error("shf_unit: internal width must be at least 2");
      end
   endgenerate

   logic [WW-1:0]      ext;
   logic               two_way;
   logic               neg;
   logic [MW-1:0]      mag;
   logic               go_left;
   logic               fill;
   logic [WW-1:0]      sh;
   logic [WW-1:0]      kp;
   logic [WW-1:0]      res_w;
   logic [Y_WIDTH-1:0] res;

   shf_extend #(.AW(A_WIDTH), .W(WW)) u_ext (
      .a_signed (a_signed),
      .a        (a),
      .ext      (ext)
   );

   assign two_way = (op == OP_BIDIR) || (op == OP_BIDIR_X);

   shf_amount #(.BW(B_WIDTH)) u_amt (
      .use_sign (b_signed & two_way),
      .b        (b),
      .neg      (neg),
      .mag      (mag)
   );

   assign go_left = (op == OP_LSL) || (op == OP_ASL) || (two_way && neg);
   assign fill    = (op == OP_ASR) && a_signed && ext[WW-1];

   shf_barrel #(.W(WW), .MW(MW)) u_bar (
      .din  (ext),
      .fill (fill),
      .left (go_left),
      .mag  (mag),
      .dout (sh),
      .keep (kp)
   );

   always_comb begin
      res_w = '0;
      case (op)
         OP_LSL, OP_LSR, OP_ASL, OP_ASR, OP_BIDIR: res_w = sh;
         OP_BIDIR_X: begin
            for (int i = 0; i < WW; i++) begin
               res_w[i] = kp[i] ? sh[i] : 1'bx;
            end
         end
         default: res_w = '0;
      endcase
   end

   assign res = res_w[Y_WIDTH-1:0];

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) y <= '0;
            else        y <= res;
         end
      end else begin : g_comb
         assign y = res;
      end
   endgenerate

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
   parameter int A_WIDTH = 12,
   parameter int B_WIDTH = 5,
   parameter int Y_WIDTH = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         op,
   input logic               a_signed,
   input logic               b_signed,
   input logic [A_WIDTH-1:0] a,
   input logic [B_WIDTH-1:0] b,
   input logic [Y_WIDTH-1:0] y
);

   localparam int WW = (A_WIDTH > Y_WIDTH) ? A_WIDTH : Y_WIDTH;

   logic [2:0]         op_q;
   logic               as_q;
   logic               bs_q;
   logic [A_WIDTH-1:0] a_q;
   logic [B_WIDTH-1:0] b_q;

   generate
      if (REG_OUT) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op_q <= '0; as_q <= 1'b0; bs_q <= 1'b0; a_q <= '0; b_q <= '0;
            end else begin
               op_q <= op; as_q <= a_signed; bs_q <= b_signed; a_q <= a; b_q <= b;
            end
         end
      end else begin : g_dir
         assign op_q = op;
         assign as_q = a_signed;
         assign bs_q = b_signed;
         assign a_q  = a;
         assign b_q  = b;
      end
   endgenerate

   // R10
   unused_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q >= 3'd6) |-> (y == '0));

   // R6
   lsl_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == 3'd0 || op_q == 3'd2) && (32'(b_q) >= WW)) |-> (y == '0));

   // R4
   asr_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == 3'd3) && as_q && a_q[A_WIDTH-1] && (32'(b_q) >= WW)) |-> (y == '1));

   // R7
   bidir_right_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == 3'd4) && !bs_q && (32'(b_q) >= WW)) |-> (y == '0));

   // R1
   lsl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == 3'd0) && (b_q != '0)) |-> (y[0] == 1'b0));

   // R11
   always @(negedge clk) begin
      if (REG_OUT && !rst_n) begin
         reset_clear_chk: assert (y == '0);
      end
   end

endmodule

bind shf_unit shf_unit_chk #(
   .A_WIDTH (A_WIDTH),
   .B_WIDTH (B_WIDTH),
   .Y_WIDTH (Y_WIDTH),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op       (op),
   .a_signed (a_signed),
   .b_signed (b_signed),
   .a        (a),
   .b        (b),
   .y        (y)
);

// File: tb/tb_shf_unit.sv
module tb_shf_unit;

   localparam int AW = 12;
   localparam int BW = 5;
   localparam int YW = 16;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op = '0;
   logic          a_signed = 1'b0;
   logic          b_signed = 1'b0;
   logic [AW-1:0] a = '0;
   logic [BW-1:0] b = '0;
   logic [YW-1:0] y;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   shf_unit #(.A_WIDTH(AW), .B_WIDTH(BW), .Y_WIDTH(YW), .REG_OUT(1'b1)) dut (
      .clk (clk), .rst_n (rst_n), .op (op), .a_signed (a_signed),
      .b_signed (b_signed), .a (a), .b (b), .y (y)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog (all requirements) got=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [WW-1:0] widen(input bit s, input logic [AW-1:0] v);
      return s ? {{(WW-AW){v[AW-1]}}, v} : {{(WW-AW){1'b0}}, v};
   endfunction

   // Returns {mask, value}; mask marks bit positions with a defined value.
   function automatic logic [2*WW-1:0] model(input logic [2:0] o, input bit as_,
                                             input bit bs_, input logic [AW-1:0] av,
                                             input logic [BW-1:0] bv);
      logic [WW-1:0] e, v, m;
      int n;
      e = widen(as_, av);
      m = '1;
      v = '0;
      case (o)
         3'd0, 3'd2: v = e << bv;
         3'd1:       v = e >> bv;
         3'd3:       v = as_ ? WW'($signed(e) >>> bv) : (e >> bv);
         3'd4, 3'd5: begin
            if (bs_ && bv[BW-1]) n = int'($signed(bv));
            else                 n = int'(bv);
            if (n < 0) begin
               v = e << (-n);
               if (o == 3'd5) m = {WW{1'b1}} << (-n);
            end else begin
               v = e >> n;
               if (o == 3'd5) m = {WW{1'b1}} >> n;
            end
         end
         default: v = '0;
      endcase
      return {m, v};
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [YW-1:0] got,
                        input logic [YW-1:0] exp, input logic [YW-1:0] msk);
      total = total + 1;
      if ((got & msk) !== (exp & msk)) begin
         bad = bad + 1;
         $display("FAIL %s got=%h exp=%h mask=%h", tag, got, exp, msk);
      end
   endtask

   // Called at a falling edge; result registered at the next rising edge.
   task automatic step(input logic [2:0] o, input bit as_, input bit bs_,
                       input logic [AW-1:0] av, input logic [BW-1:0] bv, input string tag);
      logic [2*WW-1:0] r;
      op = o; a_signed = as_; b_signed = bs_; a = av; b = bv;
      @(posedge clk);
      @(negedge clk);
      r = model(o, as_, bs_, av, bv);
      check(tag, y, r[YW-1:0], r[WW+YW-1:WW]);
   endtask

   initial begin
      logic [YW-1:0] held;
      void'($urandom(32'd20240611));
      op = 3'd1; a = 12'hABC; b = 5'd2;
      repeat (3) @(negedge clk);
      check("R11 reset", y, '0, '1);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: one clock latency
      step(3'd0, 1'b0, 1'b0, 12'h00F, 5'd4, "R11");
      held = y;
      op = 3'd1; b = 5'd1;
      #1;
      check("R11 hold", y, held, '1);
      @(negedge clk);

      // directed corners for every code
      for (int o = 0; o < 8; o++) begin
         step(3'(o), 1'b1, 1'b0, 12'h800, 5'd0,  tag_of(3'(o)));
         step(3'(o), 1'b1, 1'b0, 12'hF31, 5'd15, tag_of(3'(o)));
         step(3'(o), 1'b1, 1'b0, 12'hF31, 5'd16, "R6");
         step(3'(o), 1'b0, 1'b0, 12'hFFF, 5'd31, "R6");
         step(3'(o), 1'b1, 1'b1, 12'hA5A, 5'h10, tag_of(3'(o)));
         step(3'(o), 1'b1, 1'b1, 12'hA5A, 5'h1F, tag_of(3'(o)));
      end
      // R5: amount-signed flag ignored in plain modes
      step(3'd0, 1'b0, 1'b1, 12'h123, 5'd31, "R5");
      step(3'd1, 1'b0, 1'b1, 12'hFFF, 5'd17, "R5");
      step(3'd3, 1'b1, 1'b1, 12'h800, 5'd20, "R5");
      step(3'd3, 1'b1, 1'b1, 12'h800, 5'd3,  "R5");
      // R9: extension of the operand
      step(3'd1, 1'b1, 1'b0, 12'h801, 5'd0, "R9");
      step(3'd1, 1'b0, 1'b0, 12'h801, 5'd0, "R9");
      step(3'd3, 1'b0, 1'b0, 12'hFFF, 5'd2, "R9");
      // R7: negative amounts shift left, unsigned amounts shift right
      step(3'd4, 1'b0, 1'b1, 12'h0F0, 5'h1E, "R7");
      step(3'd4, 1'b0, 1'b0, 12'h0F0, 5'h1E, "R7");
      step(3'd5, 1'b0, 1'b1, 12'h0F0, 5'h1D, "R8");

      for (int i = 0; i < 4000; i++) begin
         logic [2:0] ro;
         ro = 3'($urandom_range(7));
         step(ro, 1'($urandom), 1'($urandom), AW'($urandom), BW'($urandom), tag_of(ro));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule